// File: doc/BRIEF.md
# Sync-Referenced Clamp Pulse Generator

This block drives the clamp strobe of a three-channel video digitizer front end. It counts pixel clock periods from the end of each horizontal sync pulse, waits a programmable number of pixels so the input can settle, then holds the strobe high for a programmable number of pixels. That window falls on the back porch, where the incoming signal carries a clean black reference. Clamping never happens during sync, because the input is driven below black at that time. A typical setting waits 4 pixels and clamps for 40.

Software can bypass the internal timing. The strobe then follows an external clamp pin whose active level is configurable. The block also presents, for each channel, the code that channel clamps to. Luma and RGB channels clamp to zero. Colour-difference channels clamp to mid-scale.

Top module: `clamp_pulse_gen`

## Requirements
- R1: While `rst_n` is low, `clamp_out` is 0 and any clamp window in progress is discarded.
- R2: Sync is active when `hsync_in` equals `hsync_pol` (1 = active-high sync, 0 = active-low sync).
- R3: Let edge k be the first rising clock edge that samples sync inactive after an edge that sampled it active. With placement P ≥ 1 and duration D ≥ 1, `clamp_out` is high after edges k+P through k+P+D−1 and low otherwise. Example: P=4, D=40.
- R4: With placement 0 and D ≥ 1, `clamp_out` goes high after edge k itself and stays high for D cycles.
- R5: With duration 0, no clamp pulse is produced after a trailing edge.
- R6: If sync is sampled active again before the window ends, `clamp_out` is low after that edge. It stays low until a new trailing edge starts a new window.
- R7: In internal mode, `clamp_out` is low in every cycle that follows an edge at which sync was sampled active.
- R8: When `ext_sel` is 1, `clamp_out` after each edge is 1 exactly when `ext_clamp_in` sampled at that edge equals `ext_pol`. Sync timing does not apply in this mode.
- R9: For each channel i (0..2), `clamp_code[10*i+9:10*i]` is 512 when `mid_sel[i]` is 1 and 0 when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync |
| hsync_pol | input | 1 | Sync active level |
| ext_clamp_in | input | 1 | External clamp pin |
| ext_pol | input | 1 | External pin active level |
| ext_sel | input | 1 | 1 = strobe taken from external pin |
| place_cnt | input | 8 | Pixels from sync end to clamp start |
| width_cnt | input | 8 | Clamp length in pixels |
| mid_sel | input | 3 | Per-channel mid-scale (1) or ground (0) clamp |
| clamp_out | output | 1 | Active-high clamp strobe |
| clamp_code | output | 30 | Per-channel clamp target code, 10 bits per channel |

## Verification
The assertions assume that the configuration inputs (polarities, source select, placement, duration) are quasi-static. They change only while no window is open, or while sync is active. The external-mode property also assumes that `ext_sel` has been steady for one cycle. The bench changes every configuration field only at a falling clock edge, before it asserts sync for a new line. It switches to external mode at least one cycle before it compares the strobe against the pin.

// File: rtl/clamp_pulse_gen.sv
`timescale 1ns/1ps
module clamp_pulse_gen #(
  parameter int CNT_W  = 8,
  parameter int CH_NUM = 3,
  parameter int CODE_W = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     hsync_in,
  input  logic                     hsync_pol,
  input  logic                     ext_clamp_in,
  input  logic                     ext_pol,
  input  logic                     ext_sel,
  input  logic [CNT_W-1:0]         place_cnt,
  input  logic [CNT_W-1:0]         width_cnt,
  input  logic [CH_NUM-1:0]        mid_sel,
  output logic                     clamp_out,
  output logic [CH_NUM*CODE_W-1:0] clamp_code
);

  localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

  typedef enum logic [1:0] {IDLE, HOLD_OFF, ACTIVE} phase_t;

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic             sync_d, int_on, ext_r;

  wire sync_act = (hsync_in == hsync_pol);
  wire ext_act  = (ext_clamp_in == ext_pol);
  wire trail    = sync_d & ~sync_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= IDLE;
      cnt    <= '0;
      sync_d <= 1'b0;
      int_on <= 1'b0;
      ext_r  <= 1'b0;
    end else begin
      sync_d <= sync_act;
      ext_r  <= ext_act;
      if (sync_act) begin
        phase  <= IDLE;
        int_on <= 1'b0;
        cnt    <= '0;
      end else if (trail) begin
        if (width_cnt == '0) begin
          phase  <= IDLE;
          int_on <= 1'b0;
        end else if (place_cnt == '0) begin
          phase  <= ACTIVE;
          int_on <= 1'b1;
          cnt    <= width_cnt - 1'b1;
        end else begin
          phase  <= HOLD_OFF;
          int_on <= 1'b0;
          cnt    <= place_cnt - 1'b1;
        end
      end else begin
        case (phase)
          HOLD_OFF:
            if (cnt != '0) cnt <= cnt - 1'b1;
            else if (width_cnt == '0) phase <= IDLE;
            else begin
              phase  <= ACTIVE;
              int_on <= 1'b1;
              cnt    <= width_cnt - 1'b1;
            end
          ACTIVE:
            if (cnt != '0) cnt <= cnt - 1'b1;
            else begin
              phase  <= IDLE;
              int_on <= 1'b0;
            end
          default: ;
        endcase
      end
    end
  end

  assign clamp_out = ext_sel ? ext_r : int_on;

  for (genvar i = 0; i < CH_NUM; i++) begin : g_code
    assign clamp_code[i*CODE_W +: CODE_W] = mid_sel[i] ? MID_CODE : '0;
  end

  // R7
  sync_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_act |=> !int_on);

  // R5
  zero_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trail && width_cnt == '0) |=> !int_on);

  // R4
  zero_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trail && place_cnt == '0 && width_cnt != '0) |=> int_on);

  // R8
  ext_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ext_sel) && ext_sel) |->
      (clamp_out == ($past(ext_clamp_in) == $past(ext_pol))));

  // R6
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_on && sync_act) |=> (phase == IDLE));

endmodule

// File: tb/clamp_pulse_gen_test.sv
`timescale 1ns/1ps
module clamp_pulse_gen_test;
  logic clk = 0, rst_n = 0;
  logic hsync_in = 0, hsync_pol = 1, ext_clamp_in = 0, ext_pol = 1, ext_sel = 0;
  logic [7:0] place_cnt = 8'd4, width_cnt = 8'd40;
  logic [2:0] mid_sel = 3'b000;
  logic clamp_out;
  logic [29:0] clamp_code;
  int tests = 0, fails = 0;

  clamp_pulse_gen uut (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .hsync_pol(hsync_pol),
    .ext_clamp_in(ext_clamp_in), .ext_pol(ext_pol), .ext_sel(ext_sel),
    .place_cnt(place_cnt), .width_cnt(width_cnt), .mid_sel(mid_sel),
    .clamp_out(clamp_out), .clamp_code(clamp_code));

  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_sync(input bit act);
    hsync_in = hsync_pol ? act : !act;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_line(input int p, input int d, input bit pol, input int n, input string req);
    @(negedge clk);
    hsync_pol = pol; place_cnt = 8'(p); width_cnt = 8'(d); ext_sel = 0;
    set_sync(1);
    repeat (3) step();
    set_sync(0);
    for (int j = 0; j < n; j++) begin
      step();
      check(req, clamp_out, (j >= p && j < p + d) ? 1 : 0);
    end
  endtask

  task automatic test_reset();
    repeat (3) step();
    check("R1", clamp_out, 0);
    rst_n = 1;
    step();
    check("R1", clamp_out, 0);
  endtask

  task automatic test_abort();
    run_line(2, 10, 1, 5, "R6");
    set_sync(1);
    for (int j = 0; j < 20; j++) begin
      step();
      check("R6_R7", clamp_out, 0);
    end
    set_sync(0);
    for (int j = 0; j < 14; j++) begin
      step();
      check("R6", clamp_out, (j >= 2 && j < 12) ? 1 : 0);
    end
  endtask

  task automatic test_ext(input bit pol);
    @(negedge clk);
    ext_pol = pol; ext_sel = 1; set_sync(1);
    step();
    for (int j = 0; j < 12; j++) begin
      bit v = ((j * 5 + 3) % 7) > 2;
      ext_clamp_in = v;
      step();
      check("R8", clamp_out, (v == pol) ? 1 : 0);
    end
    ext_sel = 0; ext_clamp_in = 0;
  endtask

  task automatic test_codes();
    for (int m = 0; m < 8; m++) begin
      mid_sel = 3'(m);
      #1;
      for (int c = 0; c < 3; c++)
        check("R9", int'(clamp_code[10*c +: 10]), m[c] ? 512 : 0);
    end
  endtask

  initial begin
    test_reset();
    run_line(4, 40, 1, 60, "R3");
    run_line(7, 3, 1, 15, "R3");
    run_line(3, 5, 0, 12, "R2");
    run_line(0, 6, 1, 10, "R4");
    run_line(0, 1, 1, 5, "R4");
    run_line(5, 0, 1, 20, "R5");
    run_line(255, 2, 1, 260, "R3");
    test_abort();
    test_ext(1);
    test_ext(0);
    test_codes();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule